// File: doc/BRIEF.md
# Double-Precision Round-and-Pack Unit

This unit sits at the end of a floating-point arithmetic pipeline. It takes a sign, an unbiased signed exponent and a normalised mantissa that carries three extra low bits (guard, round, sticky). It rounds the value to the target precision under one of four rounding modes and packs it into an IEEE 754 binary word. Alongside the word it reports inexact, underflow and overflow flags.

Tiny values take one of two paths. They are either flushed to a mode-dependent zero or smallest denormal, or aligned to the minimum exponent with a sticky right shift. A value exactly one step below the minimum exponent gets a special check: if rounding at full precision carries it up to the smallest normal, it is promoted straight there. Overflow produces infinity or the largest finite value, chosen by the mode and the sign.

The format is set by parameters. By default it is double precision: 11 exponent bits, 52 fraction bits, bias 1023, exponent range -1022..1023. One transaction is accepted per cycle with `inValid`, and results appear one cycle later with `outValid`.

Top module: `dp_round_pack`

## Requirements
- R1: `outValid` is high exactly in the cycle after a cycle with `inValid` high. Result and flags register on that edge and hold otherwise. Reset clears all outputs to zero.
- R2: Rounding mode encoding is 0 nearest-even, 1 toward zero, 2 toward +inf and 3 toward -inf. When `inMant[2:0]` is nonzero, the unit adds to the mantissa before the three low bits are dropped. Nearest-even adds 3 plus `inMant[3]`. Toward zero adds 0. Toward +inf adds 8 only when the sign is 0. Toward -inf adds 8 only when the sign is 1.
- R3: Nonzero guard/round/sticky bits, after any alignment, raise `outInexact`.
- R4: A rounding carry past the hidden bit (`inMant[FRAC_W+3]`) shifts the mantissa right by one and increments the exponent.
- R5: With `flushEn` set and the exponent below the minimum, underflow and inexact are raised. The result is a zero of the input's sign, except that it is the smallest denormal of that sign when the mode rounds away from zero for that sign (mode 2 with sign 0, or mode 3 with sign 1).
- R6: Without flush, an exponent of exactly minimum-1 whose full-precision rounding carries out of the top bit yields the smallest normal with that sign, and raises inexact.
- R7: Otherwise, an exponent below the minimum is aligned by a right shift equal to the deficit. Every bit shifted out is ORed into bit 0, and the exponent becomes the minimum.
- R8: Underflow is raised when guard bits are nonzero while the hidden bit is clear. It is also raised when a denormal is packed (exponent field 0) and `uflowTrapEn` is set. It is not raised otherwise, apart from the cases in R5.
- R9: An exponent above the maximum after rounding raises overflow and inexact, but not underflow. Mode 0 gives infinity. Mode 1 gives the largest finite value. Mode 2 gives +inf for positive values and -max for negative ones. Mode 3 gives +max for positive values and -inf for negative ones.
- R10: The result layout is sign at the top bit, then the EXP_W-bit exponent field, then FRAC_W fraction bits. A normal value stores exponent+bias with the hidden bit dropped. A value whose hidden bit is clear after rounding stores exponent field 0. A finite result never has an all-ones exponent field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input transaction strobe |
| inSign | input | 1 | Sign of the value |
| inExp | input | XE_W | Unbiased exponent, two's complement |
| inMant | input | FRAC_W+4 | Hidden bit, fraction, guard, round, sticky |
| roundMode | input | 2 | Rounding mode (R2 encoding) |
| flushEn | input | 1 | Flush tiny values instead of denormalising |
| uflowTrapEn | input | 1 | Raise underflow on every denormal result |
| outValid | output | 1 | Result strobe, one cycle after input |
| outResult | output | 1+EXP_W+FRAC_W | Packed IEEE word |
| outInexact | output | 1 | Inexact flag |
| outUnderflow | output | 1 | Underflow flag |
| outOverflow | output | 1 | Overflow flag |

## Verification
Assertions check the following on every cycle:
- valid timing;
- the flag sets forced by flush and overflow;
- inexact following nonzero guard bits;
- promotion at minimum-1 landing on exponent field 1 with a zero fraction;
- exact underflow appearing only under the trap enable;
- no finite result carrying an all-ones exponent field.

Only the bench's sweep, run on a 4-bit-exponent, 3-bit-fraction configuration, can show the actual rounded values. That covers:
- ties going to even;
- directed modes depending on the sign;
- the sticky bit surviving long shifts;
- denormals that round up into the normal range;
- the choice between infinity and largest finite for every mode and sign.

// File: rtl/rp_pkg.sv
`timescale 1ns/1ps
package rp_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } roundMode_e;

  typedef enum logic [2:0] {
    SEL_PACK,
    SEL_ZERO,
    SEL_TINY,
    SEL_INF,
    SEL_HUGE
  } packSel_e;

  // status available straight from the inputs
  typedef struct packed {
    logic belowMin;
    logic atEdge;
    logic rawCarry;
  } earlyStat_t;

  // strobes from control selecting the alignment path
  typedef struct packed {
    logic flush;
    logic edgeBump;
    logic alignShift;
  } alignStb_t;

  // status after alignment and rounding
  typedef struct packed {
    logic grsNz;
    logic hidAligned;
    logic ovf;
    logic denorm;
  } lateStat_t;

  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
  } flags_t;

endpackage

// File: rtl/rp_datapath.sv
`timescale 1ns/1ps
module rp_datapath
  import rp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int XE_W   = 13
) (
  input  logic                       sign,
  input  logic signed [XE_W-1:0]     expIn,
  input  logic [FRAC_W+3:0]          mantIn,
  input  roundMode_e                 rm,
  input  alignStb_t                  stb,
  input  packSel_e                   sel,
  output earlyStat_t                 early,
  output lateStat_t                  late,
  output logic [EXP_W+FRAC_W:0]      result
);

  localparam int M    = FRAC_W + 4;
  localparam int IW   = XE_W + 2;
  localparam int SH_W = $clog2(M + 1);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN = 1 - BIAS;
  localparam int EMAX = BIAS;
  localparam logic signed [IW-1:0] EMIN_S = IW'(EMIN);
  localparam logic signed [IW-1:0] EDGE_S = IW'(EMIN - 1);
  localparam logic signed [IW-1:0] EMAX_S = IW'(EMAX);
  localparam logic signed [IW-1:0] BIAS_S = IW'(BIAS);
  localparam logic signed [IW-1:0] M_S    = IW'(M);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [EXP_W-1:0] EXP_TOP  = EXP_ONES - 1'b1;

  // increment chosen by mode and sign, applied only when guard bits are set
  function automatic logic [M:0] roundAdd(input logic s, input logic [M-1:0] x,
                                          input roundMode_e mode);
    logic [M:0] inc;
    inc = '0;
    if (x[2:0] != 3'b000) begin
      case (mode)
        RM_NEAR: inc = (M+1)'(3) + (M+1)'(x[3]);
        RM_UP:   if (!s) inc = (M+1)'(8);
        RM_DOWN: if (s)  inc = (M+1)'(8);
        default: inc = '0;
      endcase
    end
    return {1'b0, x} + inc;
  endfunction

  logic signed [IW-1:0] expW, deficit, expAl, expOut, expBiased;
  logic [M:0]           rawRnd, rnd;
  logic [M-1:0]         shifted, lostMask, aligned, mantOut;
  logic [SH_W-1:0]      shAmt;
  logic                 sticky, carry;
  logic [FRAC_W:0]      sig;

  always_comb begin : early_c
    expW           = IW'(expIn);
    rawRnd         = roundAdd(sign, mantIn, rm);
    early.belowMin = expW < EMIN_S;
    early.atEdge   = expW == EDGE_S;
    early.rawCarry = rawRnd[M];
  end

  always_comb begin : align_c
    deficit  = EMIN_S - expW;
    shAmt    = (deficit >= M_S) ? SH_W'(M) : SH_W'(deficit);
    shifted  = mantIn >> shAmt;
    lostMask = ~({M{1'b1}} << shAmt);
    sticky   = |(mantIn & lostMask);
    aligned  = mantIn;
    expAl    = expW;
    if (stb.edgeBump) begin
      aligned = rawRnd[M:1] & ~M'(7);
      expAl   = EMIN_S;
    end else if (stb.alignShift) begin
      aligned = shifted | M'(sticky);
      expAl   = EMIN_S;
    end
  end

  always_comb begin : round_c
    rnd       = roundAdd(sign, aligned, rm);
    carry     = rnd[M];
    mantOut   = carry ? rnd[M:1] : rnd[M-1:0];
    expOut    = expAl + IW'({1'b0, carry});
    expBiased = expOut + BIAS_S;
    sig       = mantOut[M-1:3];
    late.grsNz      = |aligned[2:0];
    late.hidAligned = aligned[M-1];
    late.ovf        = expOut > EMAX_S;
    late.denorm     = ~sig[FRAC_W];
  end

  always_comb begin : pack_c
    case (sel)
      SEL_ZERO: result = {sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
      SEL_TINY: result = {sign, {EXP_W{1'b0}}, FRAC_W'(1)};
      SEL_INF:  result = {sign, EXP_ONES, {FRAC_W{1'b0}}};
      SEL_HUGE: result = {sign, EXP_TOP, {FRAC_W{1'b1}}};
      default:  result = late.denorm ? {sign, {EXP_W{1'b0}}, sig[FRAC_W-1:0]}
                                     : {sign, expBiased[EXP_W-1:0], sig[FRAC_W-1:0]};
    endcase
  end

endmodule

// File: rtl/rp_ctrl.sv
`timescale 1ns/1ps
module rp_ctrl
  import rp_pkg::*;
(
  input  logic       sign,
  input  roundMode_e rm,
  input  logic       flushEn,
  input  logic       uflowTrapEn,
  input  earlyStat_t early,
  input  lateStat_t  late,
  output alignStb_t  stb,
  output packSel_e   sel,
  output flags_t     flags
);

  logic awayMode;

  always_comb begin : stb_c
    stb.flush      = early.belowMin & flushEn;
    stb.edgeBump   = early.belowMin & ~flushEn & early.atEdge & early.rawCarry;
    stb.alignShift = early.belowMin & ~flushEn & ~stb.edgeBump;
  end

  always_comb begin : out_c
    // directed mode rounds magnitude up for this sign
    awayMode = ((rm == RM_UP) && !sign) || ((rm == RM_DOWN) && sign);
    sel      = SEL_PACK;
    flags    = '0;
    if (stb.flush) begin
      flags.inexact   = 1'b1;
      flags.underflow = 1'b1;
      sel             = awayMode ? SEL_TINY : SEL_ZERO;
    end else if (late.ovf) begin
      flags.overflow = 1'b1;
      flags.inexact  = 1'b1;
      sel            = ((rm == RM_NEAR) || awayMode) ? SEL_INF : SEL_HUGE;
    end else begin
      flags.inexact   = stb.edgeBump | late.grsNz;
      flags.underflow = (late.grsNz & ~late.hidAligned) | (late.denorm & uflowTrapEn);
    end
  end

endmodule

// File: rtl/dp_round_pack.sv
`timescale 1ns/1ps
module dp_round_pack
  import rp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int XE_W   = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   inSign,
  input  logic signed [XE_W-1:0] inExp,
  input  logic [FRAC_W+3:0]      inMant,
  input  logic [1:0]             roundMode,
  input  logic                   flushEn,
  input  logic                   uflowTrapEn,
  output logic                   outValid,
  output logic [EXP_W+FRAC_W:0]  outResult,
  output logic                   outInexact,
  output logic                   outUnderflow,
  output logic                   outOverflow
);

  localparam int RW = 1 + EXP_W + FRAC_W;

  roundMode_e        rmE;
  earlyStat_t        early;
  lateStat_t         late;
  alignStb_t         stb;
  packSel_e          sel;
  flags_t            flags;
  logic [RW-1:0]     result;

  assign rmE = roundMode_e'(roundMode);

  rp_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XE_W(XE_W)) u_dp (
    .sign   (inSign),
    .expIn  (inExp),
    .mantIn (inMant),
    .rm     (rmE),
    .stb    (stb),
    .sel    (sel),
    .early  (early),
    .late   (late),
    .result (result)
  );

  rp_ctrl u_ctrl (
    .sign        (inSign),
    .rm          (rmE),
    .flushEn     (flushEn),
    .uflowTrapEn (uflowTrapEn),
    .early       (early),
    .late        (late),
    .stb         (stb),
    .sel         (sel),
    .flags       (flags)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outResult    <= '0;
      outInexact   <= 1'b0;
      outUnderflow <= 1'b0;
      outOverflow  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outResult    <= result;
        outInexact   <= flags.inexact;
        outUnderflow <= flags.underflow;
        outOverflow  <= flags.overflow;
      end
    end
  end

  // R1: valid follows input by one cycle
  a_r1_valid_next: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_next: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3: set guard bits on a non-flushed value end up as inexact
  a_r3_grs_inexact: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && late.grsNz && !stb.flush) |=> outInexact);

  // R5: flush path flags
  a_r5_flush_flags: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && stb.flush) |=> (outUnderflow && outInexact && !outOverflow));

  // R6: promotion lands on the smallest normal
  a_r6_edge_min_normal: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && stb.edgeBump) |=>
      (outResult[RW-2:FRAC_W] == EXP_W'(1) && outResult[FRAC_W-1:0] == '0));

  // R8: exact underflow only under the trap enable
  a_r8_exact_uflow_trap: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUnderflow && !outInexact) |-> $past(uflowTrapEn));

  // R9: overflow carries inexact, never underflow
  a_r9_ovf_flags: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOverflow) |-> (outInexact && !outUnderflow));

  // R10: finite results never use the all-ones exponent field
  a_r10_finite_field: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outOverflow) |-> (outResult[RW-2:FRAC_W] != '1));

endmodule

// File: tb/test_dp_round_pack.sv
`timescale 1ns/1ps
module test_dp_round_pack;

  localparam int EW   = 4;
  localparam int FW   = 3;
  localparam int XW   = 6;
  localparam int MW   = FW + 4;
  localparam int RW   = 1 + EW + FW;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMIN = 1 - BIAS;
  localparam int EMAX = BIAS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic                 inValid = 1'b0;
  logic                 inSign = 1'b0;
  logic signed [XW-1:0] inExp = '0;
  logic [MW-1:0]        inMant = '0;
  logic [1:0]           roundMode = '0;
  logic                 flushEn = 1'b0;
  logic                 uflowTrapEn = 1'b0;
  logic                 outValid;
  logic [RW-1:0]        outResult;
  logic                 outInexact, outUnderflow, outOverflow;

  dp_round_pack #(.EXP_W(EW), .FRAC_W(FW), .XE_W(XW)) i_dp_round_pack (
    .clk, .rstN, .inValid, .inSign, .inExp, .inMant, .roundMode,
    .flushEn, .uflowTrapEn, .outValid, .outResult, .outInexact,
    .outUnderflow, .outOverflow
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic int rnd(bit s, int x, int rm);
    if ((x & 7) == 0) return x;
    case (rm)
      0: return x + 3 + ((x >> 3) & 1);
      1: return x;
      2: return s ? x : x + 8;
      default: return s ? x + 8 : x;
    endcase
  endfunction

  // Arithmetic model of R2..R10 on the small format
  task automatic model(input bit s, input int xe0, input int xm0, input int rm,
                       input bit fz, input bit ut, output logic [RW-1:0] res,
                       output bit fi, output bit fu, output bit fo, output string tag);
    int xe = xe0;
    int xm = xm0;
    int es, t;
    bit edged = 0, tinyShift = 0, grs = 0, up = 0, carried = 0;
    bit away;
    fi = 0; fu = 0; fo = 0;
    away = (rm == 2 && !s) || (rm == 3 && s);
    if (xe < EMIN) begin
      if (fz) begin
        fi = 1; fu = 1;
        res = {s, EW'(0), FW'(away ? 1 : 0)};
        tag = "R5";
        return;
      end
      if (xe == EMIN - 1 && rnd(s, xm, rm) >= (1 << MW)) begin
        fi = 1; edged = 1;
        xm = (rnd(s, xm, rm) >> 1) & ~7;
      end else begin
        es = EMIN - xe;
        tinyShift = 1;
        if (es >= MW) t = 1;
        else begin
          t = xm >> es;
          if ((xm & ((1 << es) - 1)) != 0) t = t | 1;
        end
        xm = t;
      end
      xe = EMIN;
    end
    if ((xm & 7) != 0) begin
      grs = 1; fi = 1;
      if (xm < (1 << (MW - 1))) fu = 1;
      t = rnd(s, xm, rm);
      up = (t != xm);
      if (t >= (1 << MW)) begin
        t = t >> 1; xe++; carried = 1;
      end
      xm = t;
    end
    xm = xm >> 3;
    if (xe > EMAX) begin
      fo = 1; fi = 1;
      res = (rm == 0 || away) ? {s, EW'(15), FW'(0)} : {s, EW'(14), FW'(7)};
      tag = "R9";
      return;
    end
    if (xm < (1 << FW)) begin
      if (ut) fu = 1;
      res = {s, EW'(0), FW'(xm)};
    end else begin
      res = {s, EW'(xe + BIAS), FW'(xm)};
    end
    if (edged) tag = "R6";
    else if (carried) tag = "R4";
    else if (fu) tag = "R8";
    else if (tinyShift) tag = "R7";
    else if (up) tag = "R2";
    else if (grs) tag = "R3";
    else tag = "R10";
  endtask

  logic [RW+3:0] expVec;
  string         expTag;
  bit            pend = 1'b0;

  task automatic checkPrev();
    logic [RW+3:0] act;
    if (pend) begin
      checks++;
      act = {outValid, outResult, outInexact, outUnderflow, outOverflow};
      if (act !== expVec) begin
        errors++;
        $display("FAIL %s: got %h expected %h", expTag, act, expVec);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if ({outValid, outResult, outInexact, outUnderflow, outOverflow} !== '0) begin
      errors++;
      $display("FAIL R1 reset: got %h expected 0",
               {outValid, outResult, outInexact, outUnderflow, outOverflow});
    end
    rstN = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int rm = 0; rm < 4; rm++)
        for (int fz = 0; fz < 2; fz++)
          for (int ut = 0; ut < 2; ut++)
            for (int xe = -16; xe <= 10; xe++)
              for (int lo = 0; lo < 64; lo++) begin
                logic [RW-1:0] r;
                bit fi, fu, fo;
                string tg;
                @(negedge clk);
                checkPrev();
                model(s[0], xe, 64 + lo, rm, fz[0], ut[0], r, fi, fu, fo, tg);
                expVec      = {1'b1, r, fi, fu, fo};
                expTag      = tg;
                inValid     = 1'b1;
                inSign      = s[0];
                inExp       = XW'(xe);
                inMant      = MW'(64 + lo);
                roundMode   = rm[1:0];
                flushEn     = fz[0];
                uflowTrapEn = ut[0];
                pend        = 1'b1;
              end
    @(negedge clk);
    checkPrev();
    pend = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    // R1: no valid without input, result held
    checks++;
    if (outValid !== 1'b0 || outResult !== expVec[RW+2:3]) begin
      errors++;
      $display("FAIL R1 idle: got %b/%h expected 0/%h", outValid, outResult, expVec[RW+2:3]);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule